// File: doc/BRIEF.md
# Supply-Loss Access Guard

This block sits between a host bus and a battery-backed memory with its timekeeping logic, and decides from the state of the supply whether the host may reach that memory. Two comparator flags feed it: one says the supply has dropped below the power-fail level, and the other says it has dropped below the lower level at which the backup cell must take over. Each flag first passes through a filter that accepts a new level only after it has held for a set number of clock samples. Supply noise near either threshold therefore cannot toggle the guard.

Once a power-fail is accepted, the guard closes the memory port at once. Chip select and write strobe are forced low. The read-data drive enable is dropped, which puts the host data bus in high impedance. Address and write data stay frozen at the last values the host presented while access was open, so a write that is cut off can only reach the location it was already addressing. A second, independent filtered flag hands the retention supply to the battery, and hands it back when the supply returns. After the supply recovers, protection stays in place for a programmable number of cycles. That window starts again from zero if the power-fail flag returns during it. Reset places the guard in the protected state, so every power-up passes through the same recovery window.

Top module: `supply_guard`

## Requirements
- R1: A flag (pfFlag or soFlag) is accepted at a new level only after it has been sampled at that level on DEB_LEN consecutive rising clock edges. A pulse shorter than that leaves memProtect and battSel unchanged.
- R2: memProtect goes high in the same cycle as the DEB_LEN-th clock edge that samples pfFlag high, with no further register delay. From that cycle on, memCs, memWe and busDrive are low.
- R3: While memProtect is high, host inputs are ignored. memCs, memWe and busDrive stay 0, hostRdata reads 0, and memAddr and memWdata keep the values they held when protection began, whatever hostCs, hostWe, hostOe, hostAddr and hostWdata do.
- R4: When soFlag is accepted high, battSel goes to 1 one clock edge after the edge that accepts it.
- R5: When soFlag is accepted low, battSel returns to 0 one clock edge after the edge that accepts it. If pfFlag is still accepted high, memProtect stays 1.
- R6: When pfFlag is accepted low, memProtect stays 1 for REC_CYC+1 further clock edges and falls after the last of them. Counted from the first edge that samples pfFlag low, it falls after edge DEB_LEN+REC_CYC+1.
- R7: If pfFlag is accepted high again during the recovery window, the window is abandoned. Once the supply returns, the full window of R6 runs again from zero.
- R8: While rstN is low, the guard is protected: memProtect=1, battSel=0, busDrive=0, memWe=0. After reset is released, the accepted power-fail level is taken as high, so with pfFlag low the release follows the R6 timing.
- R9: While memProtect is 0, the guard passes the host through. memCs=hostCs, memWe=hostCs&hostWe, memAddr=hostAddr, memWdata=hostWdata, busDrive=hostCs&hostOe&~hostWe, and hostRdata=memRdata when busDrive is 1, otherwise 0.
- R10: A write active when protection begins leaves memAddr and memWdata at that write's address and data. No other location is presented to the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pfFlag | input | 1 | Comparator: supply below power-fail level |
| soFlag | input | 1 | Comparator: supply below battery switchover level |
| hostCs | input | 1 | Host chip select |
| hostWe | input | 1 | Host write strobe |
| hostOe | input | 1 | Host output enable |
| hostAddr | input | AW | Host address |
| hostWdata | input | DW | Host write data |
| hostRdata | output | DW | Read data toward host (0 when not driven) |
| busDrive | output | 1 | Host data bus drive enable; 0 means high impedance |
| memRdata | input | DW | Read data from memory |
| memCs | output | 1 | Memory chip select |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Memory write data |
| memProtect | output | 1 | Deselect / write-protect indication |
| battSel | output | 1 | 1 selects the battery as retention source |

## Verification
The pass-through path is exercised over all eight combinations of hostCs, hostWe and hostOe, with several address and data values. This tells a correct strobe decode apart from swapped or merged strobes. Power-fail pulses of every length from one sample up to DEB_LEN are applied, which separates a filter that is too short from one that is too long at its exact edge. A write is cut by a power-fail, and the host then sweeps all strobe combinations and new addresses while protected; this shows whether the frozen address and data hold or leak. Finally the recovery window is timed to the cycle, both directly and with a power-fail that returns inside the window, which exposes an off-by-one count and a counter that does not restart.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DESEL   = 2'd1,
    ST_BATT    = 2'd2,
    ST_RECOVER = 2'd3
  } guard_state_t;

  typedef struct packed {
    logic accessEn;
    logic battSel;
  } guard_strobe_t;
endpackage

// File: rtl/supply_guard_filt.sv
module supply_guard_filt #(
  parameter int unsigned LEN     = 4,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic stableOut
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableOut <= RST_VAL;
      runCnt    <= '0;
    end else if (rawIn != stableOut) begin
      if (runCnt == CW'(LEN - 1)) begin
        stableOut <= rawIn;
        runCnt    <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  // R1: the accepted level only moves after a full run of matching samples
  assert_filter_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stableOut) |-> $past(runCnt) == CW'(LEN - 1));
endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
#(
  parameter int unsigned DEB_LEN = 4,
  parameter int unsigned REC_CYC = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pfFlag,
  input  logic          soFlag,
  output guard_strobe_t strobe
);
  localparam int unsigned RCW      = $clog2(REC_CYC + 1);
  localparam int unsigned NUM_FLAG = 2;
  localparam logic [NUM_FLAG-1:0] FLAG_RST = 2'b01;

  logic [NUM_FLAG-1:0] rawFlags;
  logic [NUM_FLAG-1:0] debFlags;
  logic                pfDeb;
  logic                soDeb;
  guard_state_t        state;
  guard_state_t        nextState;
  logic [RCW-1:0]      recCnt;
  logic                recDone;

  assign rawFlags = {soFlag, pfFlag};

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_filt
    supply_guard_filt #(
      .LEN     (DEB_LEN),
      .RST_VAL (FLAG_RST[g])
    ) u_filt (
      .clk       (clk),
      .rstN      (rstN),
      .rawIn     (rawFlags[g]),
      .stableOut (debFlags[g])
    );
  end

  assign pfDeb   = debFlags[0];
  assign soDeb   = debFlags[1];
  assign recDone = (recCnt == RCW'(REC_CYC - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORMAL: begin
        if (pfDeb) nextState = soDeb ? ST_BATT : ST_DESEL;
      end
      ST_DESEL: begin
        if (soDeb)       nextState = ST_BATT;
        else if (!pfDeb) nextState = ST_RECOVER;
      end
      ST_BATT: begin
        if (!soDeb) nextState = pfDeb ? ST_DESEL : ST_RECOVER;
      end
      ST_RECOVER: begin
        if (soDeb)        nextState = ST_BATT;
        else if (pfDeb)   nextState = ST_DESEL;
        else if (recDone) nextState = ST_NORMAL;
      end
      default: nextState = ST_DESEL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DESEL;
      recCnt <= '0;
    end else begin
      state <= nextState;
      if (state != ST_RECOVER || nextState != ST_RECOVER) recCnt <= '0;
      else                                                recCnt <= recCnt + 1'b1;
    end
  end

  assign strobe.accessEn = (state == ST_NORMAL) && !pfDeb;
  assign strobe.battSel  = (state == ST_BATT);

  // R6: access opens only from the recovery state
  assert_open_via_recover_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> $past(state) == ST_RECOVER);

  // R7: a returning power-fail leaves the recovery window
  assert_recover_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && pfDeb) |=> (state == ST_DESEL || state == ST_BATT));

  // R4: battery selection follows an accepted switchover flag
  assert_batt_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    soDeb |=> state == ST_BATT);
endmodule

// File: rtl/supply_guard_dp.sv
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  guard_strobe_t strobe,
  input  logic          hostCs,
  input  logic          hostWe,
  input  logic          hostOe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          busDrive,
  input  logic [DW-1:0] memRdata,
  output logic          memCs,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata
);
  logic [AW-1:0] heldAddr;
  logic [DW-1:0] heldData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldData <= '0;
    end else if (strobe.accessEn) begin
      heldAddr <= hostAddr;
      heldData <= hostWdata;
    end
  end

  assign memCs     = strobe.accessEn & hostCs;
  assign memWe     = strobe.accessEn & hostCs & hostWe;
  assign busDrive  = strobe.accessEn & hostCs & hostOe & ~hostWe;
  assign memAddr   = strobe.accessEn ? hostAddr  : heldAddr;
  assign memWdata  = strobe.accessEn ? hostWdata : heldData;
  assign hostRdata = busDrive ? memRdata : '0;

  // R3: address and data stay frozen across protected cycles
  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accessEn && $past(!strobe.accessEn)) |-> ($stable(memAddr) && $stable(memWdata)));

  // R10: the cut write keeps its own address once protection starts
  assert_cut_write_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.accessEn) && !strobe.accessEn) |-> memAddr == $past(hostAddr));
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned DEB_LEN = 4,
  parameter int unsigned REC_CYC = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pfFlag,
  input  logic          soFlag,
  input  logic          hostCs,
  input  logic          hostWe,
  input  logic          hostOe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          busDrive,
  input  logic [DW-1:0] memRdata,
  output logic          memCs,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memProtect,
  output logic          battSel
);
  guard_strobe_t strobe;

  supply_guard_ctrl #(
    .DEB_LEN (DEB_LEN),
    .REC_CYC (REC_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pfFlag (pfFlag),
    .soFlag (soFlag),
    .strobe (strobe)
  );

  supply_guard_dp #(
    .AW (AW),
    .DW (DW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostCs    (hostCs),
    .hostWe    (hostWe),
    .hostOe    (hostOe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .busDrive  (busDrive),
    .memRdata  (memRdata),
    .memCs     (memCs),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  assign memProtect = ~strobe.accessEn;
  assign battSel    = strobe.battSel;

  // R2: no write strobe reaches the memory while protected
  assert_no_write_protected_R2: assert property (@(posedge clk) disable iff (!rstN)
    memProtect |-> (!memWe && !memCs && !busDrive));
endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int DEB = 4;
  localparam int REC = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pfFlag = 1'b0, soFlag = 1'b0;
  logic          hostCs = 1'b0, hostWe = 1'b0, hostOe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] memRdata = '0;
  logic [DW-1:0] hostRdata;
  logic          busDrive, memCs, memWe, memProtect, battSel;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  supply_guard #(.AW(AW), .DW(DW), .DEB_LEN(DEB), .REC_CYC(REC)) u_dut (
    .clk(clk), .rstN(rstN), .pfFlag(pfFlag), .soFlag(soFlag),
    .hostCs(hostCs), .hostWe(hostWe), .hostOe(hostOe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .busDrive(busDrive), .memRdata(memRdata), .memCs(memCs), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memProtect(memProtect), .battSel(battSel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset state
    step(2);
    chk("R8", "memProtect", memProtect, 1);
    chk("R8", "battSel", battSel, 0);
    chk("R8", "busDrive", busDrive, 0);
    chk("R8", "memWe", memWe, 0);
    rstN = 1'b1;
    step(DEB + REC);
    chk("R8", "protect before window end", memProtect, 1);
    step(1);
    chk("R8", "protect after window", memProtect, 0);

    // R9 pass-through over all strobe combinations
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 8; c++) begin
        hostCs = c[0]; hostWe = c[1]; hostOe = c[2];
        hostAddr = AW'(a * 37 + c);
        hostWdata = DW'(a * 11 + c * 5);
        memRdata = DW'(200 - a * 7 - c);
        #1;
        chk("R9", "memCs", memCs, c[0]);
        chk("R9", "memWe", memWe, c[0] & c[1]);
        chk("R9", "busDrive", busDrive, c[0] & c[2] & ~c[1]);
        chk("R9", "memAddr", memAddr, (a * 37 + c) % 256);
        chk("R9", "memWdata", memWdata, (a * 11 + c * 5) % 256);
        chk("R9", "hostRdata", hostRdata, (c[0] & c[2] & ~c[1]) ? (200 - a * 7 - c) : 0);
      end
    end

    // R1 spikes shorter than the filter are ignored
    for (int len = 1; len < DEB; len++) begin
      pfFlag = 1'b1; soFlag = 1'b1;
      step(len);
      pfFlag = 1'b0; soFlag = 1'b0;
      step(2 * DEB);
      chk("R1", "protect after short pulse", memProtect, 0);
      chk("R1", "battSel after short pulse", battSel, 0);
    end

    // R2 / R10 power-fail during a write
    hostCs = 1; hostWe = 1; hostOe = 0; hostAddr = 8'h5A; hostWdata = 8'h33;
    pfFlag = 1'b1;
    step(DEB - 1);
    chk("R2", "protect before accept", memProtect, 0);
    chk("R2", "write still open", memWe, 1);
    step(1);
    chk("R2", "protect at accept", memProtect, 1);
    chk("R2", "memWe cut", memWe, 0);
    chk("R2", "memCs cut", memCs, 0);
    chk("R10", "memAddr of cut write", memAddr, 8'h5A);
    chk("R10", "memWdata of cut write", memWdata, 8'h33);

    // R3 host ignored while protected
    for (int c = 0; c < 8; c++) begin
      hostCs = c[0]; hostWe = c[1]; hostOe = c[2];
      hostAddr = AW'(c * 29 + 1); hostWdata = DW'(c * 13 + 2); memRdata = 8'hC3;
      step(1);
      chk("R3", "memCs", memCs, 0);
      chk("R3", "memWe", memWe, 0);
      chk("R3", "busDrive", busDrive, 0);
      chk("R3", "hostRdata", hostRdata, 0);
      chk("R3", "memAddr held", memAddr, 8'h5A);
      chk("R3", "memWdata held", memWdata, 8'h33);
    end
    hostCs = 0; hostWe = 0; hostOe = 0;

    // R4 battery take-over
    soFlag = 1'b1;
    step(DEB);
    chk("R4", "battSel at accept edge", battSel, 0);
    step(1);
    chk("R4", "battSel after accept", battSel, 1);
    chk("R4", "protect in battery", memProtect, 1);

    // R5 battery release with power-fail still present
    soFlag = 1'b0;
    step(DEB);
    chk("R5", "battSel at accept edge", battSel, 1);
    step(1);
    chk("R5", "battSel released", battSel, 0);
    chk("R5", "protect kept", memProtect, 1);

    // R6 recovery window
    pfFlag = 1'b0;
    step(DEB + REC);
    chk("R6", "protect at window end", memProtect, 1);
    step(1);
    chk("R6", "protect released", memProtect, 0);

    // R7 power-fail returns during recovery
    pfFlag = 1'b1;
    step(DEB);
    chk("R7", "protect on fail", memProtect, 1);
    pfFlag = 1'b0;
    step(DEB + 1 + 3);
    pfFlag = 1'b1;
    step(DEB);
    chk("R7", "protect on repeat fail", memProtect, 1);
    pfFlag = 1'b0;
    step(DEB + REC);
    chk("R7", "full window restarted", memProtect, 1);
    step(1);
    chk("R7", "protect released after restart", memProtect, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule